// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address for 4 KB pages. It reads one entry from a page directory and then one entry from a page table. A requester presents the address together with the access kind (read or write, user or supervisor) and the page-directory base. The walker then issues word accesses on a simple memory port. It answers with either the physical address or a fault code.

When a walk succeeds, the walker records the use of the page in memory. It sets the accessed flag of each entry that lacked it, and on a write it also sets the dirty flag of the table entry. The walker handles one walk at a time. Its ready output stays low from the moment a request is accepted until the single-cycle response has been given.

Top module: `ptw_walker`

## Requirements
- R1: The top 10 address bits select the directory entry, which is read at word address {dir_base[31:12], vaddr[31:22], 2'b00}.
- R2: The table entry is read at {directory entry bits 31:12, vaddr[21:12], 2'b00}, and only after the directory entry has been found present.
- R3: A walk with no fault returns rsp_code 0, rsp_fault 0 and rsp_paddr = {table entry bits 31:12, vaddr[11:0]}.
- R4: A directory entry with bit 0 (present) clear ends the walk with rsp_code 1, and no further memory access follows.
- R5: A table entry with bit 0 (present) clear ends the walk with rsp_code 2.
- R6: A user access (req_user=1) ends with rsp_code 4 unless bit 2 (user allowed) is set in both entries. This check wins over R7.
- R7: A write access ends with rsp_code 3 unless bit 1 (writable) is set in both entries.
- R8: After a successful walk, bit 5 (accessed) is written back into the directory entry if it was clear, and this write comes first. The table entry is then written with bit 5 set, and with bit 6 (dirty) also set on a write, but only if this changes it. A fault writes nothing.
- R9: Any fault returns rsp_fault 1 and rsp_paddr 0.
- R10: req_ready is low from the cycle after acceptance until the response cycle has ended. Requests made while busy are ignored. rsp_valid lasts exactly one cycle.
- R11: Each memory access is a one-cycle mem_req pulse. The next pulse comes only after the mem_ack that answers it, which may arrive in any later cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translate request |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user access |
| dir_base | input | 32 | Page-directory base, bits 31:12 used, sampled at acceptance |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Walk faulted |
| rsp_code | output | 3 | 0 ok, 1 dir absent, 2 table absent, 3 write, 4 user |
| rsp_paddr | output | 32 | Physical address |
| mem_req | output | 1 | Memory access pulse |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access done, read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
A request accepted at a clock edge puts its first mem_req in the following cycle. Each entry returned with mem_ack is latched at the edge that sees the ack. The next access or the response follows one cycle later, and a write-back adds two cycles plus the memory delay. Because of this, the bench does not predict a fixed response cycle. The memory model answers in the falling-edge half of the cycle, after a random delay of one to three cycles. The bench waits on rsp_valid, samples it on the falling edge, and then checks the access log and the memory image against its own reference model.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
   localparam int BIT_P = 0;
   localparam int BIT_W = 1;
   localparam int BIT_U = 2;
   localparam int BIT_A = 5;
   localparam int BIT_D = 6;

   typedef enum logic [2:0] {
      F_NONE   = 3'd0,
      F_DIR_NP = 3'd1,
      F_TBL_NP = 3'd2,
      F_WRITE  = 3'd3,
      F_USER   = 3'd4
   } fcode_t;

   typedef enum logic [3:0] {
      S_IDLE, S_DRD, S_DRDW, S_TRD, S_TRDW,
      S_DWR, S_DWRW, S_TWR, S_TWRW, S_DONE
   } wstate_t;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
   parameter int PFN_W  = 20,
   parameter int IDX_W  = 10,
   parameter int ADDR_W = 32
) (
   input  logic [PFN_W-1:0]  base_pfn,
   input  logic [IDX_W-1:0]  index,
   output logic [ADDR_W-1:0] addr
);
   localparam int BYTE_SEL = ADDR_W - PFN_W - IDX_W;

   initial begin
      assert (BYTE_SEL == 2) else $error("entry address must hold 4-byte entries");
   end

   assign addr = {base_pfn, index, {BYTE_SEL{1'b0}}};
endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
   import ptw_pkg::*;
#(
   parameter int ENT_W  = 32,
   parameter int LEVELS = 2
) (
   input  logic [LEVELS-1:0][ENT_W-1:0] ent,
   input  logic                         write,
   input  logic                         user,
   output fcode_t                       code
);
   logic [LEVELS-1:0] pres, wr_ok, us_ok;

   initial begin
      assert (LEVELS == 2) else $error("walker decodes exactly two levels");
   end

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      assign pres[g]  = ent[g][BIT_P];
      assign wr_ok[g] = ent[g][BIT_W];
      assign us_ok[g] = ent[g][BIT_U];
   end

   always_comb begin
      if (!pres[0])                 code = F_DIR_NP;
      else if (!pres[1])            code = F_TBL_NP;
      else if (user && !(&us_ok))   code = F_USER;
      else if (write && !(&wr_ok))  code = F_WRITE;
      else                          code = F_NONE;
   end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
   import ptw_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int OFF_W = 12,
   parameter int IDX_W = 10,
   parameter int ENT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   input  logic             req_user,
   input  logic [ENT_W-1:0] dir_base,
   output logic             rsp_valid,
   output logic             rsp_fault,
   output logic [2:0]       rsp_code,
   output logic [ENT_W-1:0] rsp_paddr,
   output logic             mem_req,
   output logic             mem_we,
   output logic [ENT_W-1:0] mem_addr,
   output logic [ENT_W-1:0] mem_wdata,
   input  logic             mem_ack,
   input  logic [ENT_W-1:0] mem_rdata
);
   localparam int PFN_W = ENT_W - OFF_W;
   localparam int TI_LO = OFF_W;
   localparam int DI_LO = OFF_W + IDX_W;
   localparam logic [ENT_W-1:0] A_MASK = ENT_W'(1) << BIT_A;
   localparam logic [ENT_W-1:0] D_MASK = ENT_W'(1) << BIT_D;

   initial begin
      assert (VA_W == 2 * IDX_W + OFF_W) else $error("address split mismatch");
      assert (PFN_W + IDX_W + 2 == ENT_W) else $error("entry address width mismatch");
   end

   wstate_t          state_q;
   logic [VA_W-1:0]  va_q;
   logic             wr_q, us_q, need_t_q;
   logic [PFN_W-1:0] base_q;
   logic [ENT_W-1:0] dir_q, tbl_q;
   fcode_t           code_q, perm_code;
   logic [ENT_W-1:0] dir_addr, tbl_addr;
   logic             need_t_now;

   ptw_entry_addr #(.PFN_W(PFN_W), .IDX_W(IDX_W), .ADDR_W(ENT_W)) u_dir_addr (
      .base_pfn(base_q), .index(va_q[DI_LO +: IDX_W]), .addr(dir_addr));

   ptw_entry_addr #(.PFN_W(PFN_W), .IDX_W(IDX_W), .ADDR_W(ENT_W)) u_tbl_addr (
      .base_pfn(dir_q[ENT_W-1:OFF_W]), .index(va_q[TI_LO +: IDX_W]), .addr(tbl_addr));

   ptw_perm #(.ENT_W(ENT_W), .LEVELS(2)) u_perm (
      .ent({mem_rdata, dir_q}), .write(wr_q), .user(us_q), .code(perm_code));

   assign need_t_now = !mem_rdata[BIT_A] || (wr_q && !mem_rdata[BIT_D]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= S_IDLE;
         va_q     <= '0;
         wr_q     <= 1'b0;
         us_q     <= 1'b0;
         need_t_q <= 1'b0;
         base_q   <= '0;
         dir_q    <= '0;
         tbl_q    <= '0;
         code_q   <= F_NONE;
      end else begin
         case (state_q)
            S_IDLE: if (req_valid) begin
               va_q    <= req_vaddr;
               wr_q    <= req_write;
               us_q    <= req_user;
               base_q  <= dir_base[ENT_W-1:OFF_W];
               code_q  <= F_NONE;
               state_q <= S_DRD;
            end
            S_DRD:  state_q <= S_DRDW;
            S_DRDW: if (mem_ack) begin
               dir_q <= mem_rdata;
               if (!mem_rdata[BIT_P]) begin
                  code_q  <= F_DIR_NP;
                  state_q <= S_DONE;
               end else begin
                  state_q <= S_TRD;
               end
            end
            S_TRD:  state_q <= S_TRDW;
            S_TRDW: if (mem_ack) begin
               tbl_q    <= mem_rdata;
               code_q   <= perm_code;
               need_t_q <= need_t_now;
               if (perm_code != F_NONE)  state_q <= S_DONE;
               else if (!dir_q[BIT_A])   state_q <= S_DWR;
               else if (need_t_now)      state_q <= S_TWR;
               else                      state_q <= S_DONE;
            end
            S_DWR:  state_q <= S_DWRW;
            S_DWRW: if (mem_ack) state_q <= need_t_q ? S_TWR : S_DONE;
            S_TWR:  state_q <= S_TWRW;
            S_TWRW: if (mem_ack) state_q <= S_DONE;
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state_q)
         S_DRD: begin mem_req = 1'b1; mem_addr = dir_addr; end
         S_TRD: begin mem_req = 1'b1; mem_addr = tbl_addr; end
         S_DWR: begin
            mem_req = 1'b1; mem_we = 1'b1; mem_addr = dir_addr;
            mem_wdata = dir_q | A_MASK;
         end
         S_TWR: begin
            mem_req = 1'b1; mem_we = 1'b1; mem_addr = tbl_addr;
            mem_wdata = tbl_q | A_MASK | (wr_q ? D_MASK : '0);
         end
         default: ;
      endcase
   end

   assign req_ready = (state_q == S_IDLE);
   assign rsp_valid = (state_q == S_DONE);
   assign rsp_code  = code_q;
   assign rsp_fault = (code_q != F_NONE);
   assign rsp_paddr = (code_q == F_NONE) ? {tbl_q[ENT_W-1:OFF_W], va_q[OFF_W-1:0]} : '0;

   // R11
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);
   // R10
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   // R10
   rsp_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !req_ready);
   // R8
   wb_sets_accessed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> mem_wdata[BIT_A]);
   // R4
   dir_absent_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_DRDW && mem_ack && !mem_rdata[BIT_P]) |=> (rsp_valid && rsp_code == 3'd1));
   // R9
   fault_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));
endmodule

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
   logic [31:0] req_vaddr = '0, dir_base = '0;
   logic        req_ready, rsp_valid, rsp_fault, mem_req, mem_we;
   logic [2:0]  rsp_code;
   logic [31:0] rsp_paddr, mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int errors = 0, checks = 0;
   logic [31:0] mem [logic [31:0]];
   int          acc_cnt = 0;
   logic [31:0] acc_addr [0:7];
   logic        acc_we [0:7];

   always #5 clk = ~clk;

   ptw_walker dut (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_code(logic [31:0] de, logic [31:0] te, bit wr, bit us);
      if (!de[0]) return 3'd1;
      if (!te[0]) return 3'd2;
      if (us && !(de[2] && te[2])) return 3'd4;
      if (wr && !(de[1] && te[1])) return 3'd3;
      return 3'd0;
   endfunction

   // memory model: answers 1..3 cycles after a request, on falling edges
   initial begin
      bit pend = 0;
      int cnt = 0;
      logic [31:0] a, wd;
      logic w;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         if (pend) begin
            if (mem_req) chk(0, "R11 second request while outstanding", 32'd1, 32'd0);
            if (cnt == 0) begin
               if (w) mem[a] = wd;
               mem_rdata = mem.exists(a) ? mem[a] : 32'h0;
               mem_ack = 1'b1;
               pend = 0;
            end else cnt--;
         end else if (rst_n && mem_req) begin
            a = mem_addr; w = mem_we; wd = mem_wdata;
            if (acc_cnt < 8) begin acc_addr[acc_cnt] = a; acc_we[acc_cnt] = w; end
            acc_cnt++;
            pend = 1;
            cnt = $urandom % 3;
         end
      end
   end

   task automatic walk(input logic [31:0] va, input bit wr, input bit us,
                       input logic [31:0] base, input logic [31:0] de,
                       input logic [31:0] te, input bit noise);
      logic [31:0] da = {base[31:12], va[31:22], 2'b00};
      logic [31:0] ta = {de[31:12], va[21:12], 2'b00};
      logic [2:0]  ec = exp_code(de, te, wr, us);
      logic [31:0] ede = de, ete = te, epa;
      int          ecnt, t;
      bit          dw, tw;
      mem.delete();
      mem[da] = de;
      mem[ta] = te;
      acc_cnt = 0;
      dw = (ec == 0) && !de[5];
      tw = (ec == 0) && (!te[5] || (wr && !te[6]));
      if (dw) ede = de | 32'h20;
      if (tw) ete = te | 32'h20 | (wr ? 32'h40 : 32'h0);
      epa  = (ec == 0) ? {te[31:12], va[11:0]} : 32'h0;
      ecnt = (ec == 1) ? 1 : 2 + int'(dw) + int'(tw);
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_write = wr; req_user = us; dir_base = base;
      @(negedge clk);
      chk(req_ready == 1'b0, "R10 ready low while busy", {31'b0, req_ready}, 32'h0);
      req_valid = noise; req_vaddr = ~va; req_write = ~wr; req_user = ~us;
      dir_base = ~base;
      t = 0;
      while (!rsp_valid && t < 100) begin @(negedge clk); t++; end
      if (t >= 100) begin
         chk(0, "R10 response timeout", 32'h0, 32'h1);
         return;
      end
      req_valid = 1'b0;
      chk(rsp_code == ec, "R3/R4/R5/R6/R7 code", {29'b0, rsp_code}, {29'b0, ec});
      chk(rsp_fault == (ec != 0), "R9 fault flag", {31'b0, rsp_fault}, {31'b0, ec != 0});
      chk(rsp_paddr == epa, "R3 R9 physical address", rsp_paddr, epa);
      chk(acc_cnt == ecnt, "R4 R8 access count", acc_cnt, ecnt);
      if (acc_cnt >= 1) chk(acc_addr[0] == da && !acc_we[0], "R1 directory address", acc_addr[0], da);
      if (acc_cnt >= 2) chk(acc_addr[1] == ta && !acc_we[1], "R2 table address", acc_addr[1], ta);
      if (dw && acc_cnt >= 3) chk(acc_addr[2] == da && acc_we[2], "R8 directory written first", acc_addr[2], da);
      chk(mem[da] == ede, "R8 directory entry", mem[da], ede);
      chk(mem[ta] == ete, "R8 table entry", mem[ta], ete);
      @(negedge clk);
      chk(!rsp_valid && req_ready, "R10 single-cycle response", {30'b0, rsp_valid, req_ready}, 32'h1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(0, "watchdog", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req, "reset state", {29'b0, req_ready, rsp_valid, mem_req}, 32'h4);
      rst_n = 1'b1;
      // directed corners
      walk(32'h1234_5678, 0, 0, 32'h0001_0000, 32'h0002_0006, 32'h0003_0007, 0); // R4 dir absent
      walk(32'hFFC0_0ABC, 0, 0, 32'h0001_0000, 32'h0002_0027, 32'h0003_0006, 0); // R5 table absent
      walk(32'h0040_1FFF, 1, 1, 32'h0001_0000, 32'h0002_0021, 32'h0003_0021, 0); // R6 wins over R7
      walk(32'h0040_1000, 1, 0, 32'h0001_0000, 32'h0002_0025, 32'h0003_0067, 0); // R7 dir not writable
      walk(32'h0040_1000, 0, 1, 32'h0001_0000, 32'h0002_0027, 32'h0003_0063, 0); // R6 table supervisor
      walk(32'h8000_0123, 0, 1, 32'h0005_0000, 32'h0006_0027, 32'h0007_0027, 0); // R8 nothing to write
      walk(32'h8000_0123, 1, 0, 32'h0005_0000, 32'h0006_0003, 32'h0007_0003, 0); // R8 dir then table with dirty
      walk(32'h8000_0123, 1, 0, 32'h0005_0000, 32'h0006_0023, 32'h0007_0023, 1); // R8 dirty only, R10 noise
      for (int i = 0; i < 300; i++) begin
         logic [31:0] b, de, te;
         b  = {$urandom, 12'h0} & 32'hFFFF_F000;
         de = $urandom;
         te = $urandom;
         de[0] = ($urandom % 10) != 0;
         te[0] = ($urandom % 10) != 0;
         if (de[31:12] == b[31:12]) de[31:12] = ~b[31:12];
         walk($urandom, 1'($urandom), 1'($urandom), b, de, te, 1'($urandom));
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule